// File: doc/BRIEF.md
# Eight-Pin Port Configuration Register File

This block holds the configuration state of one port of up to eight pads and makes it reachable in two layouts at once. Seen by attribute, each setting (output data, the three drive-mode bits, the sampled pin level, bidirectional enable, slow slew, output bypass) is one register with one bit per pin. Seen by pin, each pin has one byte that holds all of its settings. A third, write-only broadcast register pushes the same drive-mode upper bits, bypass, slew and bidirectional settings to every pin in a single write. Every view is backed by the same flip-flops, so a write through any view shows up at once in the others.

Two write channels feed the storage. The port-wide channel carries attribute-register and broadcast writes. The per-pin channel carries pin-byte writes. When both channels hit the same pin in one cycle, the per-pin write wins on that pin. One combinational read port serves both layouts. The block also turns each pin's three-bit drive mode and its effective data bit into pad controls: output enable, output value, pull-up and pull-down enables, and input-buffer enable.

Top module: `pinbank_cfg`

## Requirements
- R1: After reset, every readable register reads 0. Every pin is in mode 0: pad_oe, pull_up, pull_dn, pad_ibuf, slow_o and bidir_o are all 0.
- R2: A port-wide write to pw_addr a (a in 0..7, a not 4) loads bit p of pw_wdata into attribute a of pin p. The attribute numbers are 0 data, 1 mode bit0, 2 mode bit1, 3 mode bit2, 5 bidirectional enable, 6 slow slew, 7 bypass. A read at rd_addr a returns that row.
- R3: A per-pin write with pp_pin = p loads pin p from pp_wdata in the same layout: bit0 data, bit1 mode bit0, bit2 mode bit1, bit3 mode bit2, bit4 pin level, bit5 bidirectional enable, bit6 slow slew, bit7 bypass. A read at rd_addr 8+p returns pin p's byte in that layout.
- R4: Both layouts read the same storage. A value written through either view reads back through the other with no extra cycle.
- R5: A port-wide write to pw_addr 8 (broadcast) copies pw_wdata bits 2, 3, 5, 6 and 7 into those attributes of every pin. The data and mode-bit0 attributes of all pins are left unchanged.
- R6: The pin-level attribute (rd_addr 4, and bit4 of each pin byte) shows pin_in as registered on the previous clock edge. Writes to it through either channel are ignored.
- R7: When the two channels write in the same cycle, the pin named by pp_pin takes every stored attribute from pp_wdata. All other pins take the port-wide write.
- R8: Drive mode m = {mode bit2, bit1, bit0} with effective data d gives these pad controls. Mode 0: all off, input buffer off. Mode 1: outputs off. Mode 2: oe=!d, pull_up=d. Mode 3: oe=d, pull_dn=!d. Mode 4: oe=!d. Mode 5: oe=d. Mode 6: oe=1. Mode 7: pull_up=d, pull_dn=!d. pad_ibuf is 1 for modes 1 to 7. pad_val is d.
- R9: The effective data d of a pin is alt_out of that pin when its bypass bit is 1, and its data bit otherwise.
- R10: slow_o and bidir_o give each pin's slow-slew and bidirectional-enable bits directly.
- R11: Read addresses 16 to 31, and pin bytes for pins at or above NPINS, read as 0. Port-wide write addresses 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pw_we | input | 1 | Port-wide channel write strobe |
| pw_addr | input | 4 | Attribute index 0..7, or 8 for broadcast |
| pw_wdata | input | 8 | Port-wide write data |
| pp_we | input | 1 | Per-pin channel write strobe |
| pp_pin | input | PIW | Pin index for the per-pin write |
| pp_wdata | input | 8 | Pin byte to write |
| rd_addr | input | 5 | Read address: 0..7 attribute rows, 8..15 pin bytes |
| rd_data | output | 8 | Read data (combinational) |
| pin_in | input | NPINS | Pad input levels |
| alt_out | input | NPINS | Output data used when bypass is set |
| pad_oe | output | NPINS | Pad strong-drive enable |
| pad_val | output | NPINS | Pad output value |
| pull_up | output | NPINS | Resistive pull-up enable |
| pull_dn | output | NPINS | Resistive pull-down enable |
| pad_ibuf | output | NPINS | Digital input buffer enable |
| slow_o | output | NPINS | Slow slew select |
| bidir_o | output | NPINS | Bidirectional enable |

## Verification
On every cycle, the assertions check four things. The pad controls never enable a drive and a pull at the same time. Nothing is driven while the input buffer is off. The pin-level row follows the previous cycle's pin_in. Each attribute write, broadcast write and same-cycle collision leaves the storage as R2, R5 and R7 require. Other behaviour can only be shown by the bench's scenarios: cross-view readback, the exact pad pattern for each of the eight modes, bypass selection and the zero reads of unmapped addresses.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   localparam int NATTR     = 8;
   localparam int A_DATA    = 0;
   localparam int A_MODE0   = 1;
   localparam int A_MODE1   = 2;
   localparam int A_MODE2   = 3;
   localparam int A_LEVEL   = 4;
   localparam int A_BIDIR   = 5;
   localparam int A_SLOW    = 6;
   localparam int A_BYPASS  = 7;
   localparam int PW_AW     = 4;
   localparam int RD_AW     = 5;
   localparam logic [PW_AW-1:0] BCAST_ADDR = 4'd8;
   // attributes that the broadcast register touches
   localparam logic [NATTR-1:0] BCAST_MASK = 8'b1110_1100;
   // attributes held in writable storage
   localparam logic [NATTR-1:0] STORED_MASK = 8'b1110_1111;

   typedef enum logic [2:0] {
      DM_ANALOG_Z  = 3'd0,
      DM_DIGITAL_Z = 3'd1,
      DM_PULL_UP   = 3'd2,
      DM_PULL_DN   = 3'd3,
      DM_OD_LOW    = 3'd4,
      DM_OD_HIGH   = 3'd5,
      DM_STRONG    = 3'd6,
      DM_PULL_BOTH = 3'd7
   } drive_mode_e;
endpackage

// File: rtl/pinbank_store.sv
module pinbank_store
   import pinbank_pkg::*;
#(
   parameter int NPINS = 8,
   parameter int PIW   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pw_we,
   input  logic [PW_AW-1:0]            pw_addr,
   input  logic [NATTR-1:0]            pw_wdata,
   input  logic                        pp_we,
   input  logic [PIW-1:0]              pp_pin,
   input  logic [NATTR-1:0]            pp_wdata,
   input  logic [NPINS-1:0]            pin_in,
   output logic [NATTR-1:0][NPINS-1:0] attr_q
);
   logic row_wr;
   logic bc_wr;

   assign row_wr = pw_we && (pw_addr < PW_AW'(NATTR));
   assign bc_wr  = pw_we && (pw_addr == BCAST_ADDR);

   for (genvar a = 0; a < NATTR; a++) begin : g_attr
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         logic bit_q;
         if (a == A_LEVEL) begin : g_level
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) bit_q <= 1'b0;
               else        bit_q <= pin_in[p];
            end
         end else begin : g_cfg
            logic pp_hit;
            logic row_hit;
            logic bc_hit;
            assign pp_hit  = pp_we && (pp_pin == PIW'(p));
            assign row_hit = row_wr && (pw_addr[2:0] == 3'(a));
            assign bc_hit  = bc_wr && BCAST_MASK[a];
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       bit_q <= 1'b0;
               else if (pp_hit)  bit_q <= pp_wdata[a];
               else if (row_hit) bit_q <= pw_wdata[p];
               else if (bc_hit)  bit_q <= pw_wdata[a];
            end
         end
         assign attr_q[a][p] = bit_q;
      end
   end
endmodule

// File: rtl/pinbank_rdmux.sv
module pinbank_rdmux
   import pinbank_pkg::*;
#(
   parameter int NPINS = 8
) (
   input  logic [NATTR-1:0][NPINS-1:0] attr_q,
   input  logic [RD_AW-1:0]            rd_addr,
   output logic [NATTR-1:0]            rd_data
);
   logic [NATTR-1:0][NATTR-1:0] rows;
   logic [NATTR-1:0][NATTR-1:0] cols;

   for (genvar a = 0; a < NATTR; a++) begin : g_row
      for (genvar p = 0; p < NATTR; p++) begin : g_bit
         if (p < NPINS) begin : g_live
            assign rows[a][p] = attr_q[a][p];
            assign cols[p][a] = attr_q[a][p];
         end else begin : g_pad
            assign rows[a][p] = 1'b0;
            assign cols[p][a] = 1'b0;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr[4:3])
         2'b00:   rd_data = rows[rd_addr[2:0]];
         2'b01:   rd_data = cols[rd_addr[2:0]];
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/pinbank_drive.sv
module pinbank_drive
   import pinbank_pkg::*;
(
   input  logic [2:0] mode,
   input  logic       dr,
   input  logic       byp,
   input  logic       alt,
   output logic       oe,
   output logic       val,
   output logic       pu,
   output logic       pd,
   output logic       ibuf
);
   logic d;
   assign d   = byp ? alt : dr;
   assign val = d;

   always_comb begin
      oe   = 1'b0;
      pu   = 1'b0;
      pd   = 1'b0;
      ibuf = 1'b1;
      case (drive_mode_e'(mode))
         DM_ANALOG_Z:  ibuf = 1'b0;
         DM_DIGITAL_Z: ;
         DM_PULL_UP:   begin oe = ~d; pu = d;  end
         DM_PULL_DN:   begin oe = d;  pd = ~d; end
         DM_OD_LOW:    oe = ~d;
         DM_OD_HIGH:   oe = d;
         DM_STRONG:    oe = 1'b1;
         DM_PULL_BOTH: begin pu = d;  pd = ~d; end
         default:      ibuf = 1'b0;
      endcase
   end
endmodule

// File: rtl/pinbank_cfg.sv
module pinbank_cfg
   import pinbank_pkg::*;
#(
   parameter int NPINS = 8,
   parameter int PIW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pw_we,
   input  logic [3:0]           pw_addr,
   input  logic [7:0]           pw_wdata,
   input  logic                 pp_we,
   input  logic [PIW-1:0]       pp_pin,
   input  logic [7:0]           pp_wdata,
   input  logic [4:0]           rd_addr,
   output logic [7:0]           rd_data,
   input  logic [NPINS-1:0]     pin_in,
   input  logic [NPINS-1:0]     alt_out,
   output logic [NPINS-1:0]     pad_oe,
   output logic [NPINS-1:0]     pad_val,
   output logic [NPINS-1:0]     pull_up,
   output logic [NPINS-1:0]     pull_dn,
   output logic [NPINS-1:0]     pad_ibuf,
   output logic [NPINS-1:0]     slow_o,
   output logic [NPINS-1:0]     bidir_o
);
   if (NPINS < 1 || NPINS > NATTR) begin : g_bad_npins
      $error("pinbank_cfg: NPINS must lie in 1..8");
   end
   if (PIW < 1 || (1 << PIW) < NPINS) begin : g_bad_piw
      $error("pinbank_cfg: PIW too narrow for NPINS");
   end

   logic [NATTR-1:0][NPINS-1:0] attr_q;

   pinbank_store #(.NPINS(NPINS), .PIW(PIW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .pw_we    (pw_we),
      .pw_addr  (pw_addr),
      .pw_wdata (pw_wdata),
      .pp_we    (pp_we),
      .pp_pin   (pp_pin),
      .pp_wdata (pp_wdata),
      .pin_in   (pin_in),
      .attr_q   (attr_q)
   );

   pinbank_rdmux #(.NPINS(NPINS)) u_rdmux (
      .attr_q  (attr_q),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   for (genvar p = 0; p < NPINS; p++) begin : g_pad
      pinbank_drive u_drive (
         .mode ({attr_q[A_MODE2][p], attr_q[A_MODE1][p], attr_q[A_MODE0][p]}),
         .dr   (attr_q[A_DATA][p]),
         .byp  (attr_q[A_BYPASS][p]),
         .alt  (alt_out[p]),
         .oe   (pad_oe[p]),
         .val  (pad_val[p]),
         .pu   (pull_up[p]),
         .pd   (pull_dn[p]),
         .ibuf (pad_ibuf[p])
      );
   end

   assign slow_o  = attr_q[A_SLOW];
   assign bidir_o = attr_q[A_BIDIR];
endmodule

// File: rtl/pinbank_cfg_chk.sv
module pinbank_cfg_chk
   import pinbank_pkg::*;
#(
   parameter int NPINS = 8,
   parameter int PIW   = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        pw_we,
   input logic [3:0]                  pw_addr,
   input logic [7:0]                  pw_wdata,
   input logic                        pp_we,
   input logic [PIW-1:0]              pp_pin,
   input logic [7:0]                  pp_wdata,
   input logic [NPINS-1:0]            pin_in,
   input logic [NATTR-1:0][NPINS-1:0] attr_q,
   input logic [NPINS-1:0]            pad_oe,
   input logic [NPINS-1:0]            pull_up,
   input logic [NPINS-1:0]            pull_dn,
   input logic [NPINS-1:0]            pad_ibuf
);
   logic live;
   logic [NPINS-1:0][NATTR-1:0] cols;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   for (genvar a = 0; a < NATTR; a++) begin : g_a
      for (genvar p = 0; p < NPINS; p++) begin : g_p
         assign cols[p][a] = attr_q[a][p];
      end
   end

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && pull_up == '0 && pull_dn == '0 && pad_ibuf == '0));

   p_row_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_we && !pp_we && pw_addr < 4'd8 && pw_addr != 4'd4)
      |=> attr_q[$past(pw_addr[2:0])] == $past(pw_wdata[NPINS-1:0]));

   p_bcast_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_we && !pp_we && pw_addr == 4'd8)
      |=> (attr_q[A_DATA] == $past(attr_q[A_DATA]) &&
           attr_q[A_MODE0] == $past(attr_q[A_MODE0]) &&
           attr_q[A_MODE1] == {NPINS{$past(pw_wdata[A_MODE1])}} &&
           attr_q[A_BYPASS] == {NPINS{$past(pw_wdata[A_BYPASS])}}));

   p_level_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> attr_q[A_LEVEL] == $past(pin_in));

   p_pin_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_we && 32'(pp_pin) < NPINS)
      |=> (cols[$past(pp_pin)] & STORED_MASK) == ($past(pp_wdata) & STORED_MASK));

   p_no_fight_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & (pull_up | pull_dn)) == '0);

   p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (~pad_ibuf & (pad_oe | pull_up | pull_dn)) == '0);
endmodule

bind pinbank_cfg pinbank_cfg_chk #(.NPINS(NPINS), .PIW(PIW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pw_we    (pw_we),
   .pw_addr  (pw_addr),
   .pw_wdata (pw_wdata),
   .pp_we    (pp_we),
   .pp_pin   (pp_pin),
   .pp_wdata (pp_wdata),
   .pin_in   (pin_in),
   .attr_q   (attr_q),
   .pad_oe   (pad_oe),
   .pull_up  (pull_up),
   .pull_dn  (pull_dn),
   .pad_ibuf (pad_ibuf)
);

// File: tb/pinbank_cfg_tb.sv
`timescale 1ns/1ps
module pinbank_cfg_tb_top;
   localparam int NP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pw_we = 1'b0;
   logic [3:0] pw_addr = '0;
   logic [7:0] pw_wdata = '0;
   logic       pp_we = 1'b0;
   logic [2:0] pp_pin = '0;
   logic [7:0] pp_wdata = '0;
   logic [4:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] alt_out = '0;
   logic [NP-1:0] pad_oe, pad_val, pull_up, pull_dn, pad_ibuf, slow_o, bidir_o;

   always #2.5 clk = ~clk;

   pinbank_cfg #(.NPINS(NP)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .pw_we(pw_we), .pw_addr(pw_addr), .pw_wdata(pw_wdata),
      .pp_we(pp_we), .pp_pin(pp_pin), .pp_wdata(pp_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pin_in(pin_in), .alt_out(alt_out),
      .pad_oe(pad_oe), .pad_val(pad_val), .pull_up(pull_up), .pull_dn(pull_dn),
      .pad_ibuf(pad_ibuf), .slow_o(slow_o), .bidir_o(bidir_o)
   );

   typedef struct {
      int          kind;   // 0: read data, 1: pad bundle
      logic [63:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   // reference state: rows 0..7 in attribute order, row 4 = sampled level
   logic [7:0] m [8];

   function automatic logic [7:0] exp_read(input logic [4:0] a);
      logic [7:0] r = '0;
      if (a < 5'd8) r = m[a[2:0]];
      else if (a < 5'd16) begin
         for (int k = 0; k < 8; k++) r[k] = m[k][a[2:0]];
      end
      return r;
   endfunction

   function automatic logic [55:0] exp_pads();
      logic [7:0] oe = '0, va = '0, pu = '0, pd = '0, ib = '0;
      for (int p = 0; p < NP; p++) begin
         logic [2:0] md;
         logic d;
         md = {m[3][p], m[2][p], m[1][p]};
         d  = m[7][p] ? alt_out[p] : m[0][p];
         va[p] = d;
         ib[p] = (md != 3'd0);
         case (md)
            3'd2: begin oe[p] = ~d; pu[p] = d; end
            3'd3: begin oe[p] = d; pd[p] = ~d; end
            3'd4: oe[p] = ~d;
            3'd5: oe[p] = d;
            3'd6: oe[p] = 1'b1;
            3'd7: begin pu[p] = d; pd[p] = ~d; end
            default: ;
         endcase
      end
      return {oe, va, pu, pd, ib, m[6], m[5]};
   endfunction

   function automatic void mdl_pw(input logic [3:0] a, input logic [7:0] d);
      if (a < 4'd8 && a != 4'd4) m[a[2:0]] = d;
      else if (a == 4'd8) begin
         foreach (m[k]) if (k == 2 || k == 3 || k >= 5) m[k] = {8{d[k]}};
      end
   endfunction

   function automatic void mdl_pp(input logic [2:0] p, input logic [7:0] d);
      for (int k = 0; k < 8; k++) if (k != 4) m[k][p] = d[k];
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic pw_write(input logic [3:0] a, input logic [7:0] d);
      pw_we = 1; pw_addr = a; pw_wdata = d;
      tick();
      pw_we = 0;
      mdl_pw(a, d);
   endtask

   task automatic pp_write(input logic [2:0] p, input logic [7:0] d);
      pp_we = 1; pp_pin = p; pp_wdata = d;
      tick();
      pp_we = 0;
      mdl_pp(p, d);
   endtask

   task automatic both_write(input logic [3:0] a, input logic [7:0] d,
                             input logic [2:0] p, input logic [7:0] pd);
      pw_we = 1; pw_addr = a; pw_wdata = d;
      pp_we = 1; pp_pin = p; pp_wdata = pd;
      tick();
      pw_we = 0; pp_we = 0;
      mdl_pw(a, d);
      mdl_pp(p, pd);
   endtask

   task automatic chk_read(input logic [4:0] a, input string req);
      item_t it;
      rd_addr = a;
      it.kind = 0; it.exp = {56'b0, exp_read(a)}; it.req = req;
      q.push_back(it);
      tick();
   endtask

   task automatic chk_pads(input string req);
      item_t it;
      it.kind = 1; it.exp = {8'b0, exp_pads()}; it.req = req;
      q.push_back(it);
      tick();
   endtask

   // monitor
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         logic [63:0] act;
         it = q.pop_front();
         if (it.kind == 0) act = {56'b0, rd_data};
         else act = {8'b0, pad_oe, pad_val, pull_up, pull_dn, pad_ibuf, slow_o, bidir_o};
         n_chk++;
         if (act !== it.exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h (rd_addr=%0d)", it.req, act, it.exp, rd_addr);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      foreach (m[k]) m[k] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();

      // R1: reset contents and idle pads
      for (int a = 0; a < 16; a++) chk_read(5'(a), "R1 reset readback");
      chk_pads("R1 reset pads");

      // R2: attribute rows, one pattern each
      pw_write(4'd0, 8'hA5);
      pw_write(4'd1, 8'h3C);
      pw_write(4'd2, 8'h0F);
      pw_write(4'd3, 8'hF0);
      pw_write(4'd5, 8'h96);
      pw_write(4'd6, 8'h5A);
      pw_write(4'd7, 8'h00);
      for (int a = 0; a < 8; a++) chk_read(5'(a), "R2 row readback");
      // R4: pin view reflects row writes
      for (int p = 0; p < 8; p++) chk_read(5'(8 + p), "R4 pin view after row writes");
      // R10: raw slew and bidir bits reach pads
      chk_pads("R10 slew bidir and R8 decode");

      // R3: per-pin writes, R4 row view after
      pp_write(3'd2, 8'b1101_0110);
      pp_write(3'd7, 8'b0011_1001);
      chk_read(5'd10, "R3 pin2 byte");
      chk_read(5'd15, "R3 pin7 byte");
      for (int a = 0; a < 8; a++) chk_read(5'(a), "R4 row view after pin writes");

      // R6: level row read-only and registered
      pin_in = 8'h6E;
      pw_write(4'd4, 8'hFF);
      m[4] = 8'h6E;
      chk_read(5'd4, "R6 level row ignores write");
      pp_write(3'd1, 8'b0001_0000);
      chk_read(5'd9, "R6 pin byte level bit");
      pin_in = 8'h81;
      chk_read(5'd4, "R6 level lags pin_in by one edge");
      m[4] = 8'h81;
      chk_read(5'd4, "R6 level updated");

      // R5: broadcast keeps data and mode0
      pw_write(4'd8, 8'hFF);
      for (int a = 0; a < 8; a++) chk_read(5'(a), "R5 broadcast all ones");
      pw_write(4'd8, 8'b0100_1011);
      for (int a = 0; a < 8; a++) chk_read(5'(a), "R5 broadcast mixed");

      // R11: ignored write addresses and unmapped reads
      pw_write(4'd9, 8'hFF);
      pw_write(4'd15, 8'h00);
      for (int a = 0; a < 16; a++) chk_read(5'(a), "R11 no effect of addr 9..15");
      for (int a = 16; a < 32; a++) chk_read(5'(a), "R11 unmapped read zero");

      // R7: same-cycle collision, pin view wins on its pin
      both_write(4'd0, 8'hFF, 3'd3, 8'h00);
      chk_read(5'd0, "R7 data row after collision");
      chk_read(5'd11, "R7 winning pin byte");
      both_write(4'd8, 8'hEC, 3'd5, 8'b0000_1010);
      for (int p = 0; p < 8; p++) chk_read(5'(8 + p), "R7 broadcast vs pin write");

      // R8, R9: every mode on every pin, both data values, with and without bypass
      for (int r = 0; r < 8; r++) begin
         for (int p = 0; p < 8; p++) begin
            logic [2:0] md;
            logic [7:0] b;
            md = 3'((r + p) % 8);
            b = {1'b0, 3'b000, md, 1'((p + r) >> 1)};
            pp_write(3'(p), b);
         end
         chk_pads("R8 mode decode");
         pw_write(4'd0, ~m[0]);
         chk_pads("R8 mode decode inverted data");
         alt_out = 8'(8'h35 + r * 8'h17);
         pw_write(4'd7, 8'hC3);
         chk_pads("R9 bypass selects alt_out");
         alt_out = ~alt_out;
         chk_pads("R9 bypass follows alt_out");
         pw_write(4'd7, 8'h00);
      end

      tick();
      tick();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule